// File: doc/BRIEF.md
# Reference-Aligned Auxiliary Square-Wave Generator

This block drives a square wave whose edges are locked to a periodic alignment pulse from a timing reference. Each clock of the counting domain is one tick (2 ns at 500 MHz). Software sets three 16-bit tick counts: the high time, the low time and a coarse phase shift. Setting high and low separately gives any period and any duty cycle. When the alignment pulse arrives, the output goes low for the shift count. It then alternates high and low phases until the next pulse restarts the sequence. The phase relative to the reference is therefore repeatable.

The same register set carries requested tap values out to two external delay elements: one on the generated signal and one on the one-pulse-per-second signal. It also returns each element's current tap value and the signal element's lock flag. Access is through a Wishbone-style single-cycle slave port. Only bits [4:0] of the byte address are decoded: 0x00 high width, 0x04 low width, 0x08 shift, 0x0C signal delay word, 0x10 PPS delay word. Any other address reads zero and ignores writes.

Top module: `aux_clk_gen`

## Requirements
- R1: After reset the high width reads 25, the low width 25 and the shift 15, and both requested tap outputs are 0. The output is low and stays low until the first alignment pulse.
- R2: The width and shift words hold their value in bits [15:0] and read back exactly what was written, with bits [31:16] zero.
- R3: Bits [4:0] written to the word at 0x0C appear on `sigTapSet`, and bits [4:0] written to 0x10 appear on `ppsTapSet`, from the cycle after the write. Bits [4:0] of both words read as zero.
- R4: Word 0x0C reads `sigTapCur` in bits [12:8] and `sigLocked` in bit 31. Word 0x10 reads `ppsTapCur` in bits [12:8] and has bit 31 zero.
- R5: An alignment pulse sampled at a clock edge starts this sequence: the output is low for S cycles (S = shift), then high for H cycles, then low for L cycles. The H and L phases repeat.
- R6: With a shift of zero, the output is high in the cycle right after the edge that sampled the pulse.
- R7: A width written during a phase takes effect only at the next entry to a phase of that kind. A phase already running keeps its length.
- R8: A width of zero behaves as a width of one tick.
- R9: An alignment pulse restarts the sequence from the shift phase whatever phase is running. The shift used is the value held in the register at that edge.
- R10: `wbAck` goes high for exactly one cycle, in the cycle after a request (`wbCyc` and `wbStb`) is sampled. A write takes effect at that same edge, and read data is valid while `wbAck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock of the counting domain |
| rstN | input | 1 | Active-low synchronous reset |
| wbCyc | input | 1 | Bus cycle valid |
| wbStb | input | 1 | Bus strobe |
| wbWe | input | 1 | Write enable |
| wbAdr | input | 5 | Byte address |
| wbDatIn | input | 32 | Write data |
| wbDatOut | output | 32 | Read data |
| wbAck | output | 1 | Transfer acknowledge |
| alignPulse | input | 1 | Periodic alignment pulse, one cycle wide |
| sigTapCur | input | 5 | Current tap of the signal delay element |
| sigLocked | input | 1 | Lock flag of the signal delay element |
| ppsTapCur | input | 5 | Current tap of the PPS delay element |
| sigTapSet | output | 5 | Requested tap for the signal delay element |
| ppsTapSet | output | 5 | Requested tap for the PPS delay element |
| clkOut | output | 1 | Generated square wave |

## Verification
The waveform is run several ways:
- Default 25/25/15 settings after a single pulse, which shows whether the shift and phase counts are off by one.
- A zero shift with unequal widths, which separates the direct start in the high phase from a one-tick shift.
- Zero widths, which must toggle every tick rather than stall.
- A width rewrite in the middle of a high phase, which tells a deferred load apart from a truncated pulse.
- A pulse landing in the middle of a low phase, which checks the restart.

A behavioural model in the bench predicts the output for every cycle. Register reads with distinct tap and lock inputs show which bit fields are placed where and which fields read as zero.

// File: rtl/aux_clk_pkg.sv
package aux_clk_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_HIGH  = 2'd2,
    PH_LOW   = 2'd3
  } phase_t;

  typedef struct packed {
    logic ldShift;
    logic ldHigh;
    logic ldLow;
    logic cntEn;
    logic wrStb;
    logic rdStb;
  } genStrobes_t;
endpackage

// File: rtl/aux_clk_ctrl.sv
module aux_clk_ctrl
  import aux_clk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wbCyc,
  input  logic        wbStb,
  input  logic        wbWe,
  input  logic        alignPulse,
  input  logic        cntLast,
  input  logic        shiftZero,
  output genStrobes_t stb,
  output logic        wbAck,
  output logic        clkOut
);
  phase_t phase, phaseNext;
  logic   ldShift, ldHigh, ldLow;

  always_comb begin
    phaseNext = phase;
    ldShift   = 1'b0;
    ldHigh    = 1'b0;
    ldLow     = 1'b0;
    if (alignPulse) begin
      if (shiftZero) begin
        phaseNext = PH_HIGH;
        ldHigh    = 1'b1;
      end else begin
        phaseNext = PH_SHIFT;
        ldShift   = 1'b1;
      end
    end else if (cntLast) begin
      unique case (phase)
        PH_SHIFT: begin phaseNext = PH_HIGH; ldHigh = 1'b1; end
        PH_HIGH:  begin phaseNext = PH_LOW;  ldLow  = 1'b1; end
        PH_LOW:   begin phaseNext = PH_HIGH; ldHigh = 1'b1; end
        default:  phaseNext = phase;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      wbAck <= 1'b0;
    end else begin
      phase <= phaseNext;
      wbAck <= wbCyc & wbStb & ~wbAck;
    end
  end

  always_comb begin
    stb.ldShift = ldShift;
    stb.ldHigh  = ldHigh;
    stb.ldLow   = ldLow;
    stb.cntEn   = (phase != PH_IDLE);
    stb.wrStb   = wbCyc & wbStb & wbWe & ~wbAck;
    stb.rdStb   = wbCyc & wbStb & ~wbWe & ~wbAck;
  end

  assign clkOut = (phase == PH_HIGH);

  p_ack_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    wbAck |=> !wbAck);
  p_ack_follows_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && wbStb && !wbAck) |=> wbAck);
  p_align_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    alignPulse |=> (phase == PH_SHIFT || phase == PH_HIGH));
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && !alignPulse) |=> !clkOut);
  p_zero_shift_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (alignPulse && shiftZero) |=> clkOut);
endmodule

// File: rtl/aux_clk_dpath.sv
module aux_clk_dpath
  import aux_clk_pkg::*;
#(
  parameter int TICK_W    = 16,
  parameter int TAP_W     = 5,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int DEF_HIGH  = 25,
  parameter int DEF_LOW   = 25,
  parameter int DEF_SHIFT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  genStrobes_t       stb,
  input  logic [ADDR_W-1:0] wbAdr,
  input  logic [DATA_W-1:0] wbDatIn,
  input  logic [TAP_W-1:0]  sigTapCur,
  input  logic              sigLocked,
  input  logic [TAP_W-1:0]  ppsTapCur,
  output logic [DATA_W-1:0] wbDatOut,
  output logic [TAP_W-1:0]  sigTapSet,
  output logic [TAP_W-1:0]  ppsTapSet,
  output logic              cntLast,
  output logic              shiftZero
);
  localparam int TAP_CUR_LSB = 8;
  localparam int LOCK_BIT    = DATA_W - 1;
  localparam logic [ADDR_W-1:0] A_HIGH  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LOW   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SHIFT = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_SIGD  = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_PPSD  = ADDR_W'(16);

  logic [TICK_W-1:0] highW, lowW, shiftW, cnt;
  logic [TICK_W-1:0] effHigh, effLow;
  logic [DATA_W-1:0] rdMux;
  logic              unusedDat;

  assign unusedDat = ^wbDatIn[DATA_W-1:TICK_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highW     <= TICK_W'(DEF_HIGH);
      lowW      <= TICK_W'(DEF_LOW);
      shiftW    <= TICK_W'(DEF_SHIFT);
      sigTapSet <= '0;
      ppsTapSet <= '0;
    end else if (stb.wrStb) begin
      unique case (wbAdr)
        A_HIGH:  highW     <= wbDatIn[TICK_W-1:0];
        A_LOW:   lowW      <= wbDatIn[TICK_W-1:0];
        A_SHIFT: shiftW    <= wbDatIn[TICK_W-1:0];
        A_SIGD:  sigTapSet <= wbDatIn[TAP_W-1:0];
        A_PPSD:  ppsTapSet <= wbDatIn[TAP_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdMux = '0;
    unique case (wbAdr)
      A_HIGH:  rdMux[TICK_W-1:0] = highW;
      A_LOW:   rdMux[TICK_W-1:0] = lowW;
      A_SHIFT: rdMux[TICK_W-1:0] = shiftW;
      A_SIGD: begin
        rdMux[TAP_CUR_LSB +: TAP_W] = sigTapCur;
        rdMux[LOCK_BIT]             = sigLocked;
      end
      A_PPSD:  rdMux[TAP_CUR_LSB +: TAP_W] = ppsTapCur;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)           wbDatOut <= '0;
    else if (stb.rdStb)  wbDatOut <= rdMux;
  end

  assign effHigh   = (highW == '0) ? TICK_W'(1) : highW;
  assign effLow    = (lowW  == '0) ? TICK_W'(1) : lowW;
  assign shiftZero = (shiftW == '0);

  always_ff @(posedge clk) begin
    if (!rstN)             cnt <= '0;
    else if (stb.ldShift)  cnt <= shiftW;
    else if (stb.ldHigh)   cnt <= effHigh;
    else if (stb.ldLow)    cnt <= effLow;
    else if (stb.cntEn)    cnt <= cnt - TICK_W'(1);
  end

  assign cntLast = stb.cntEn && (cnt == TICK_W'(1));

  p_cnt_live_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntEn |-> (cnt != '0));
  p_sig_tap_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStb && wbAdr == A_SIGD) |=> (sigTapSet == $past(wbDatIn[TAP_W-1:0])));
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrStb |=> ($stable(highW) && $stable(lowW) && $stable(shiftW)));
  p_width_defer_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cntEn && !stb.ldShift && !stb.ldHigh && !stb.ldLow) |=> (cnt == $past(cnt) - TICK_W'(1)));
endmodule

// File: rtl/aux_clk_gen.sv
module aux_clk_gen
  import aux_clk_pkg::*;
#(
  parameter int TICK_W    = 16,
  parameter int TAP_W     = 5,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int DEF_HIGH  = 25,
  parameter int DEF_LOW   = 25,
  parameter int DEF_SHIFT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [ADDR_W-1:0] wbAdr,
  input  logic [DATA_W-1:0] wbDatIn,
  output logic [DATA_W-1:0] wbDatOut,
  output logic              wbAck,
  input  logic              alignPulse,
  input  logic [TAP_W-1:0]  sigTapCur,
  input  logic              sigLocked,
  input  logic [TAP_W-1:0]  ppsTapCur,
  output logic [TAP_W-1:0]  sigTapSet,
  output logic [TAP_W-1:0]  ppsTapSet,
  output logic              clkOut
);
  genStrobes_t stb;
  logic        cntLast, shiftZero;

  aux_clk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .alignPulse(alignPulse), .cntLast(cntLast), .shiftZero(shiftZero),
    .stb(stb), .wbAck(wbAck), .clkOut(clkOut)
  );

  aux_clk_dpath #(
    .TICK_W(TICK_W), .TAP_W(TAP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DEF_HIGH(DEF_HIGH), .DEF_LOW(DEF_LOW), .DEF_SHIFT(DEF_SHIFT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wbAdr(wbAdr), .wbDatIn(wbDatIn),
    .sigTapCur(sigTapCur), .sigLocked(sigLocked), .ppsTapCur(ppsTapCur),
    .wbDatOut(wbDatOut), .sigTapSet(sigTapSet), .ppsTapSet(ppsTapSet),
    .cntLast(cntLast), .shiftZero(shiftZero)
  );
endmodule

// File: tb/test_aux_clk_gen.sv
module test_aux_clk_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wbCyc = 1'b0, wbStb = 1'b0, wbWe = 1'b0;
  logic [4:0]  wbAdr = '0;
  logic [31:0] wbDatIn = '0;
  logic [31:0] wbDatOut;
  logic        wbAck;
  logic        alignPulse = 1'b0;
  logic [4:0]  sigTapCur = '0, ppsTapCur = '0;
  logic        sigLocked = 1'b0;
  logic [4:0]  sigTapSet, ppsTapSet;
  logic        clkOut;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  aux_clk_gen i_aux_clk_gen (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbDatIn(wbDatIn), .wbDatOut(wbDatOut), .wbAck(wbAck),
    .alignPulse(alignPulse), .sigTapCur(sigTapCur), .sigLocked(sigLocked),
    .ppsTapCur(ppsTapCur), .sigTapSet(sigTapSet), .ppsTapSet(ppsTapSet),
    .clkOut(clkOut)
  );

  // behavioural model: mode 0 idle, 1 shift, 2 high, 3 low
  int mHigh, mLow, mShift, mode, remain;
  logic mAck;

  always @(posedge clk) begin
    if (!rstN) begin
      mHigh = 25; mLow = 25; mShift = 15; mode = 0; remain = 0; mAck = 1'b0;
    end else begin
      if (alignPulse) begin
        if (mShift == 0) begin mode = 2; remain = (mHigh == 0) ? 1 : mHigh; end
        else begin mode = 1; remain = mShift; end
      end else if (mode != 0) begin
        remain = remain - 1;
        if (remain == 0) begin
          if (mode == 2) begin mode = 3; remain = (mLow == 0) ? 1 : mLow; end
          else begin mode = 2; remain = (mHigh == 0) ? 1 : mHigh; end
        end
      end
      if (wbCyc && wbStb && wbWe && !mAck) begin
        case (wbAdr)
          5'h00: mHigh = int'(wbDatIn[15:0]);
          5'h04: mLow = int'(wbDatIn[15:0]);
          5'h08: mShift = int'(wbDatIn[15:0]);
          default: ;
        endcase
      end
      mAck = wbCyc && wbStb && !mAck;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      total++;
      if (clkOut !== (mode == 2)) begin
        bad++;
        $display("FAIL %s clkOut actual=%b expected=%b t=%0t", tag, clkOut, (mode == 2), $time);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busAccess(input logic we, input logic [4:0] adr, input logic [31:0] dat,
                           output logic [31:0] rd);
    @(negedge clk);
    wbCyc = 1'b1; wbStb = 1'b1; wbWe = we; wbAdr = adr; wbDatIn = dat;
    @(negedge clk);
    check("R10 ack after one cycle", {31'd0, wbAck}, 32'd1);
    rd = wbDatOut;
    wbCyc = 1'b0; wbStb = 1'b0; wbWe = 1'b0;
    @(negedge clk);
    check("R10 ack single cycle", {31'd0, wbAck}, 32'd0);
  endtask

  task automatic wr(input logic [4:0] adr, input logic [31:0] dat);
    logic [31:0] d;
    busAccess(1'b1, adr, dat, d);
  endtask

  task automatic rdChk(input string req, input logic [4:0] adr, input logic [31:0] exp);
    logic [31:0] d;
    busAccess(1'b0, adr, 32'd0, d);
    check(req, d, exp);
  endtask

  task automatic pulse();
    @(negedge clk);
    alignPulse = 1'b1;
    @(negedge clk);
    alignPulse = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    tag = "R1";
    check("R1 clkOut low after reset", {31'd0, clkOut}, 32'd0);
    check("R1 sigTapSet reset", {27'd0, sigTapSet}, 32'd0);
    check("R1 ppsTapSet reset", {27'd0, ppsTapSet}, 32'd0);
    rdChk("R1 high default", 5'h00, 32'd25);
    rdChk("R1 low default", 5'h04, 32'd25);
    rdChk("R1 shift default", 5'h08, 32'd15);
    idle(20);

    tag = "R3";
    wr(5'h0C, 32'hFFFF_FFEA);
    check("R3 sigTapSet passthrough", {27'd0, sigTapSet}, 32'h0A);
    wr(5'h10, 32'h0000_0013);
    check("R3 ppsTapSet passthrough", {27'd0, ppsTapSet}, 32'h13);
    check("R3 sigTapSet untouched by 0x10", {27'd0, sigTapSet}, 32'h0A);

    sigTapCur = 5'h11; ppsTapCur = 5'h05; sigLocked = 1'b1;
    rdChk("R4 signal delay word", 5'h0C, 32'h8000_1100);
    rdChk("R4 pps delay word", 5'h10, 32'h0000_0500);
    sigLocked = 1'b0; sigTapCur = 5'h1F;
    rdChk("R4 signal word unlocked", 5'h0C, 32'h0000_1F00);

    tag = "R2";
    wr(5'h00, 32'hABCD_1234);
    rdChk("R2 high readback", 5'h00, 32'h0000_1234);
    wr(5'h00, 32'd25);
    rdChk("R2 high restored", 5'h00, 32'd25);

    tag = "R5";
    pulse();
    idle(200);

    tag = "R6";
    wr(5'h08, 32'd0);
    wr(5'h00, 32'd3);
    wr(5'h04, 32'd5);
    pulse();
    check("R6 high right after pulse", {31'd0, clkOut}, 32'd1);
    idle(60);

    tag = "R8";
    wr(5'h00, 32'd0);
    wr(5'h04, 32'd0);
    pulse();
    idle(30);

    tag = "R7";
    wr(5'h00, 32'd10);
    wr(5'h04, 32'd4);
    wr(5'h08, 32'd2);
    pulse();
    idle(5);
    wr(5'h00, 32'd2);
    idle(40);

    tag = "R9";
    wr(5'h00, 32'd6);
    wr(5'h04, 32'd9);
    wr(5'h08, 32'd3);
    pulse();
    idle(10);
    pulse();
    idle(40);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule